// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table kept in memory. A requester presents the virtual address, a process identifier, a write flag and the physical base of the top-level (master) table. The walker then reads the master entry, uses the frame number in that entry to find the secondary table, reads the secondary entry, and reports either the leaf entry together with the physical address, or a fault.

The virtual address is split as 10 bits of master index (bits 31:22), 10 bits of secondary index (bits 21:12) and a 12-bit page offset (bits 11:0). Entries are 4 bytes wide, so each table is 1024 entries and fills one 4 KB page. In an entry, bit 0 means present, bit 1 means writable, bit 2 means referenced, bit 3 means modified, and bits 31:12 hold the frame number. Memory is reached through a read port where a one-cycle request pulse carries an address and the reply arrives later with its own valid strobe. Any number of wait cycles is allowed. The walker handles one walk at a time.

Top module: `pgwalk_top`

## Requirements
- R1: The first memory read of a walk is a single-cycle request at address `root_base + 4*vaddr[31:22]`.
- R2: When the master entry has bit 0 set, a second single-cycle read follows at address `{master_entry[31:12], 12'h000} + 4*vaddr[21:12]`.
- R3: When the secondary entry is usable, `done_valid` pulses, `done_pte` equals the secondary entry, and `done_paddr` equals `{secondary_entry[31:12], vaddr[11:0]}`.
- R4: A master entry with bit 0 clear ends the walk with `fault_valid`, `fault_prot`=0 and `fault_level`=0, and no second read is issued.
- R5: A secondary entry with bit 0 clear ends the walk with `fault_valid`, `fault_prot`=0 and `fault_level`=1.
- R6: A write request whose secondary entry is present but has bit 1 clear ends with `fault_valid`, `fault_prot`=1 and `fault_level`=1. A read request completes whatever bit 1 holds.
- R7: During a fault pulse, `fault_vaddr` and `fault_pid` equal the virtual address and process identifier of the request that faulted.
- R8: `done_valid` and `fault_valid` are never high together, each stays high for exactly one cycle, and every walk produces exactly one of them.
- R9: A request is accepted only while `busy` is low. A request held high while a walk is in flight starts nothing: the in-flight walk's result is unchanged, and no further read appears after the walk ends.
- R10: After reset, `busy`, `mem_req_valid`, `done_valid` and `fault_valid` are all low.
- R11: The walker waits for each memory reply however many cycles it takes, and `busy` stays high from acceptance until the cycle after the result pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a walk (taken when `busy` is low) |
| req_write | input | 1 | The access is a store |
| req_vaddr | input | 32 | Virtual address to translate |
| req_pid | input | 8 | Process identifier of the requester |
| root_base | input | 32 | Physical base of the master table |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Memory read request pulse |
| mem_req_addr | output | 32 | Memory read address |
| mem_rsp_valid | input | 1 | Memory read data is valid |
| mem_rsp_data | input | 32 | Memory read data |
| done_valid | output | 1 | Translation complete pulse |
| done_pte | output | 32 | Leaf entry of the finished walk |
| done_paddr | output | 32 | Translated physical address |
| fault_valid | output | 1 | Page fault pulse |
| fault_prot | output | 1 | 1 = protection fault, 0 = not-present fault |
| fault_level | output | 1 | 0 = master level, 1 = secondary level |
| fault_vaddr | output | 32 | Faulting virtual address |
| fault_pid | output | 8 | Faulting process identifier |

## Verification
A corrupted latch of the virtual address or the table base shows up on `mem_req_addr` in the very first request cycle. A wrong secondary base shows up in the second request cycle. If the state register takes a wrong branch, the port shows a missing or extra read, or a result pulse of the wrong kind or level, or a result pulse that lasts longer than one cycle or never arrives. All of these appear within a few cycles of the reply that caused them. The sweep covers every master index and several secondary indices, offsets, reply latencies and access kinds. It compares each read address and each result against an entry pattern that the bench computes arithmetically.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD1  = 3'd1,
    ST_WT1  = 3'd2,
    ST_RD2  = 3'd3,
    ST_WT2  = 3'd4,
    ST_DONE = 3'd5,
    ST_FLT  = 3'd6
  } walk_state_e;

  // entry bit positions
  localparam int PTE_V_BIT = 0;
  localparam int PTE_W_BIT = 1;
  localparam int PTE_R_BIT = 2;
  localparam int PTE_M_BIT = 3;

endpackage

// File: rtl/pgwalk_addr.sv
// Read address and physical address arithmetic for the walk.
module pgwalk_addr #(
  parameter int VA_W      = 32,
  parameter int OFF_W     = 12,
  parameter int PTE_BYTES = 4
) (
  input  logic [VA_W-1:0]       vaddr,
  input  logic [VA_W-1:0]       root_base,
  input  logic [VA_W-OFF_W-1:0] l1_frame,
  input  logic                  sel_l2,
  input  logic [VA_W-OFF_W-1:0] leaf_frame,
  output logic [VA_W-1:0]       rd_addr,
  output logic [VA_W-1:0]       paddr
);
  localparam int IDX_W = (VA_W - OFF_W) / 2;
  localparam int SH    = $clog2(PTE_BYTES);
  localparam int PADW  = VA_W - IDX_W - SH;

  logic [IDX_W-1:0] idx_master;
  logic [IDX_W-1:0] idx_second;
  logic [VA_W-1:0]  off_master;
  logic [VA_W-1:0]  off_second;
  logic [VA_W-1:0]  second_base;

  always_comb begin
    idx_master  = vaddr[VA_W-1 -: IDX_W];
    idx_second  = vaddr[OFF_W +: IDX_W];
    off_master  = {{PADW{1'b0}}, idx_master, {SH{1'b0}}};
    off_second  = {{PADW{1'b0}}, idx_second, {SH{1'b0}}};
    second_base = {l1_frame, {OFF_W{1'b0}}};
    rd_addr     = sel_l2 ? (second_base + off_second) : (root_base + off_master);
    paddr       = {leaf_frame, vaddr[OFF_W-1:0]};
  end
endmodule

// File: rtl/pgwalk_pte_chk.sv
// Classifies one fetched entry.
module pgwalk_pte_chk (
  input  logic v_bit,
  input  logic w_bit,
  input  logic is_leaf,
  input  logic is_write,
  output logic absent,
  output logic prot
);
  always_comb begin
    absent = !v_bit;
    prot   = v_bit && is_leaf && is_write && !w_bit;
  end
endmodule

// File: rtl/pgwalk_fsm.sv
// Walk sequencing.
module pgwalk_fsm
  import pgwalk_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        req_fire,
  input  logic        rsp_valid,
  input  logic        absent,
  input  logic        prot,
  output walk_state_e state
);
  walk_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (req_fire) nxt = ST_RD1;
      ST_RD1:  nxt = ST_WT1;
      ST_WT1:  if (rsp_valid) nxt = absent ? ST_FLT : ST_RD2;
      ST_RD2:  nxt = ST_WT2;
      ST_WT2:  if (rsp_valid) nxt = (absent || prot) ? ST_FLT : ST_DONE;
      ST_DONE: nxt = ST_IDLE;
      ST_FLT:  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int OFF_W     = 12,
  parameter int PID_W     = 8,
  parameter int PTE_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [PID_W-1:0] req_pid,
  input  logic [VA_W-1:0]  root_base,
  output logic             busy,
  output logic             mem_req_valid,
  output logic [VA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [VA_W-1:0]  mem_rsp_data,
  output logic             done_valid,
  output logic [VA_W-1:0]  done_pte,
  output logic [VA_W-1:0]  done_paddr,
  output logic             fault_valid,
  output logic             fault_prot,
  output logic             fault_level,
  output logic [VA_W-1:0]  fault_vaddr,
  output logic [PID_W-1:0] fault_pid
);
  localparam int FRAME_W = VA_W - OFF_W;

  walk_state_e        state;
  logic               req_fire;
  logic [VA_W-1:0]    va_q;
  logic [VA_W-1:0]    base_q;
  logic [PID_W-1:0]   pid_q;
  logic               wr_q;
  logic [FRAME_W-1:0] l1_frame_q;
  logic               absent;
  logic               prot;
  logic               in_l2;
  logic [VA_W-1:0]    rd_addr;
  logic [VA_W-1:0]    paddr;
  logic [VA_W-1:0]    pte_q;
  logic [VA_W-1:0]    paddr_q;
  logic               prot_q;
  logic               lvl_q;

  assign req_fire = req_valid && (state == ST_IDLE);
  assign in_l2    = (state == ST_RD2) || (state == ST_WT2);

  pgwalk_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_fire  (req_fire),
    .rsp_valid (mem_rsp_valid),
    .absent    (absent),
    .prot      (prot),
    .state     (state)
  );

  pgwalk_addr #(
    .VA_W      (VA_W),
    .OFF_W     (OFF_W),
    .PTE_BYTES (PTE_BYTES)
  ) u_addr (
    .vaddr      (va_q),
    .root_base  (base_q),
    .l1_frame   (l1_frame_q),
    .sel_l2     (in_l2),
    .leaf_frame (mem_rsp_data[VA_W-1:OFF_W]),
    .rd_addr    (rd_addr),
    .paddr      (paddr)
  );

  pgwalk_pte_chk u_pte (
    .v_bit    (mem_rsp_data[PTE_V_BIT]),
    .w_bit    (mem_rsp_data[PTE_W_BIT]),
    .is_leaf  (in_l2),
    .is_write (wr_q),
    .absent   (absent),
    .prot     (prot)
  );

  // request capture
  always_ff @(posedge clk) begin
    if (rst) begin
      va_q   <= '0;
      base_q <= '0;
      pid_q  <= '0;
      wr_q   <= 1'b0;
    end else if (req_fire) begin
      va_q   <= req_vaddr;
      base_q <= root_base;
      pid_q  <= req_pid;
      wr_q   <= req_write;
    end
  end

  // master entry capture and result registers
  always_ff @(posedge clk) begin
    if (rst) begin
      l1_frame_q <= '0;
      pte_q      <= '0;
      paddr_q    <= '0;
      prot_q     <= 1'b0;
      lvl_q      <= 1'b0;
    end else if (mem_rsp_valid) begin
      if (state == ST_WT1) begin
        l1_frame_q <= mem_rsp_data[VA_W-1:OFF_W];
        prot_q     <= 1'b0;
        lvl_q      <= 1'b0;
      end else if (state == ST_WT2) begin
        pte_q   <= mem_rsp_data;
        paddr_q <= paddr;
        prot_q  <= prot;
        lvl_q   <= 1'b1;
      end
    end
  end

  assign busy          = (state != ST_IDLE);
  assign mem_req_valid = (state == ST_RD1) || (state == ST_RD2);
  assign mem_req_addr  = rd_addr;
  assign done_valid    = (state == ST_DONE);
  assign done_pte      = pte_q;
  assign done_paddr    = paddr_q;
  assign fault_valid   = (state == ST_FLT);
  assign fault_prot    = prot_q;
  assign fault_level   = lvl_q;
  assign fault_vaddr   = va_q;
  assign fault_pid     = pid_q;
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
  parameter int VA_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            busy,
  input logic            mem_req_valid,
  input logic            done_valid,
  input logic [VA_W-1:0] done_pte,
  input logic            fault_valid,
  input logic            fault_prot,
  input logic            fault_level
);
  // R1
  mem_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);

  // R8
  excl_result_chk: assert property (@(posedge clk) disable iff (rst)
    !(done_valid && fault_valid));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid);

  // R8
  fault_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fault_valid |=> !fault_valid);

  // R3
  done_present_chk: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> done_pte[0]);

  // R6
  prot_level_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_valid && fault_prot) |-> fault_level);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_req_valid && !done_valid && !fault_valid));

  // R11
  start_read_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> mem_req_valid);
endmodule

bind pgwalk_top pgwalk_chk #(.VA_W(VA_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .busy          (busy),
  .mem_req_valid (mem_req_valid),
  .done_valid    (done_valid),
  .done_pte      (done_pte),
  .fault_valid   (fault_valid),
  .fault_prot    (fault_prot),
  .fault_level   (fault_level)
);

// File: tb/pgwalk_top_bench.sv
`timescale 1ns/1ps
module pgwalk_top_bench;
  localparam logic [31:0] ROOT = 32'h0004_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [7:0]  req_pid = '0;
  logic [31:0] root_base = ROOT;
  logic        busy;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        done_valid;
  logic [31:0] done_pte;
  logic [31:0] done_paddr;
  logic        fault_valid;
  logic        fault_prot;
  logic        fault_level;
  logic [31:0] fault_vaddr;
  logic [7:0]  fault_pid;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int mem_lat = 1;

  always #4 clk = ~clk;

  pgwalk_top u_pgwalk_top (.*);

  // ---- arithmetic table contents ----
  function automatic logic [31:0] l1_word(input int i);
    logic [19:0] fr;
    fr = 20'(256 + i);
    if (i % 3 == 0) return {fr, 12'h000};
    return {fr, 10'h0, 1'(i & 1), 1'b1};
  endfunction

  function automatic logic [31:0] l2_word(input int i, input int j);
    logic [19:0] fr;
    logic v, w, r, m;
    fr = {10'(i), 10'(j)} ^ 20'hA5A5A;
    v  = ((i + j) % 5) != 0;
    w  = ((i ^ j) & 1) == 0;
    r  = 1'(j & 1);
    m  = 1'((j >> 1) & 1);
    return {fr, 8'h00, m, r, w, v};
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    int pg;
    pg = int'(a[31:12]);
    if (a[31:12] == ROOT[31:12]) return l1_word(int'(a[11:2]));
    if (pg >= 256 && pg < 256 + 1024) return l2_word(pg - 256, int'(a[11:2]));
    return 32'h0;
  endfunction

  // ---- memory model ----
  int          n_rd = 0;
  logic [31:0] alog [0:3];
  logic        pend = 1'b0;
  int          pcnt = 0;
  logic [31:0] paddr_m = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
      pend          <= 1'b0;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid) begin
        alog[n_rd % 4] <= mem_req_addr;
        n_rd    <= n_rd + 1;
        pend    <= 1'b1;
        pcnt    <= mem_lat - 1;
        paddr_m <= mem_req_addr;
      end else if (pend) begin
        if (pcnt == 0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= mem_word(paddr_m);
          pend          <= 1'b0;
        end else begin
          pcnt <= pcnt - 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    wait (cyc > 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", cyc, 200000);
    finish_run();
  end

  task automatic walk(input int i, input int j, input int off, input bit wr,
                      input logic [7:0] pid, input int lat, input bit pester);
    logic [31:0] va, e1, e2, exp_addr2;
    int s, waited;
    bit seen_done, seen_fault, v1, v2, wbit;
    va = {10'(i), 10'(j), 12'(off)};
    e1 = l1_word(i);
    e2 = l2_word(256 + i - 256, j);
    v1 = e1[0];
    v2 = e2[0];
    wbit = e2[1];
    exp_addr2 = {e1[31:12], 12'h000} + 32'(4 * j);
    mem_lat = lat;
    s = n_rd;
    @(negedge clk);
    chk(!busy, "R9 idle before request", 32'(busy), 0);
    req_valid = 1'b1; req_vaddr = va; req_write = wr; req_pid = pid;
    @(negedge clk);
    chk(busy && mem_req_valid, "R11 busy and first read", {busy, mem_req_valid}, 2'b11);
    if (pester) begin
      req_vaddr = ~va; req_write = ~wr; req_pid = ~pid;
    end else begin
      req_valid = 1'b0;
    end
    seen_done = 0; seen_fault = 0; waited = 0;
    while (!seen_done && !seen_fault && waited < 40) begin
      if (!(done_valid || fault_valid)) begin
        @(negedge clk);
        waited++;
      end
      seen_done  = done_valid;
      seen_fault = fault_valid;
    end
    req_valid = 1'b0;
    chk(alog[s % 4] == ROOT + 32'(4 * i), "R1 master read address", alog[s % 4], ROOT + 32'(4 * i));
    if (!v1) begin
      chk(seen_fault && !seen_done, "R4 master absent faults", {seen_done, seen_fault}, 2'b01);
      chk(n_rd - s == 1, "R4 single read", 32'(n_rd - s), 1);
      chk({fault_prot, fault_level} == 2'b00, "R4 fault kind/level", {fault_prot, fault_level}, 2'b00);
    end else begin
      chk(n_rd - s == 2, "R2 two reads", 32'(n_rd - s), 2);
      chk(alog[(s + 1) % 4] == exp_addr2, "R2 secondary read address", alog[(s + 1) % 4], exp_addr2);
      if (!v2) begin
        chk(seen_fault && !seen_done, "R5 secondary absent faults", {seen_done, seen_fault}, 2'b01);
        chk({fault_prot, fault_level} == 2'b01, "R5 fault kind/level", {fault_prot, fault_level}, 2'b01);
      end else if (wr && !wbit) begin
        chk(seen_fault && !seen_done, "R6 protection fault", {seen_done, seen_fault}, 2'b01);
        chk({fault_prot, fault_level} == 2'b11, "R6 fault kind/level", {fault_prot, fault_level}, 2'b11);
      end else begin
        chk(seen_done && !seen_fault, "R3 translation done", {seen_done, seen_fault}, 2'b10);
        chk(done_pte == e2, "R3 leaf entry", done_pte, e2);
        chk(done_paddr == {e2[31:12], va[11:0]}, "R3 physical address", done_paddr, {e2[31:12], va[11:0]});
      end
    end
    if (seen_fault) begin
      chk(fault_vaddr == va, "R7 fault vaddr", fault_vaddr, va);
      chk(fault_pid == pid, "R7 fault pid", 32'(fault_pid), 32'(pid));
    end
    s = n_rd;
    @(negedge clk);
    chk(!done_valid && !fault_valid, "R8 one-cycle result", {done_valid, fault_valid}, 0);
    chk(!busy, "R11 busy clears after result", 32'(busy), 0);
    @(negedge clk);
    chk(n_rd == s && !busy, "R9 held request ignored", 32'(n_rd - s), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req_valid && !done_valid && !fault_valid, "R10 reset outputs",
        {busy, mem_req_valid, done_valid, fault_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !mem_req_valid, "R10 idle after reset", {busy, mem_req_valid}, 0);
    for (int i = 0; i < 1024; i++) begin
      for (int k = 0; k < 3; k++) begin
        walk(i, (i * 7 + k * 341) % 1024, (i * 13 + k * 1111) % 4096, (k != 0),
             8'(i ^ k), 1 + (i + k) % 3, (k == 2));
      end
    end
    // read access to a non-writable present leaf (i=1, j=2: i^j odd, (i+j)%5!=0)
    walk(1, 2, 12'hFFF, 1'b0, 8'h5A, 4, 1'b0);
    // same leaf written: protection fault (R6)
    walk(1, 2, 12'h000, 1'b1, 8'hA5, 5, 1'b1);
    finish_run();
  end
endmodule